// File: doc/BRIEF.md
# Narrow-to-Wide Write Width Adapter

This block joins a 256-bit memory-mapped write master to a 512-bit write slave. Every narrow beat the master accepts is steered into the lower or the upper 256-bit half of a wide word. The adapter builds the 64 wide byte enables itself, so the half that a beat does not cover is never written. The master uses byte addresses and gives only the first address of a burst. The adapter derives the address of each later beat itself, stepping 32 bytes per beat.

A mode input, `pack_mode`, is sampled on the first beat of each burst. With packing off, every narrow beat becomes its own single-beat wide write at its own word address. With packing on, a beat for the lower half is held while more beats follow. The next beat, for the upper half, then goes out with it as one wide write. The packed slave burst is presented at the start word address, with a wide burst count worked out from the narrow count and the starting half.

Top module: `nww_write_widener`

## Requirements
- R1: The slave write strobe is never asserted while the master write strobe is low. After reset, the adapter is idle: the next master beat is a first beat, and no half held from before the reset appears in any later write.
- R2: With packing off, each accepted narrow beat produces exactly one slave write, with `s_burst` = 1 and `s_addr` = (beat byte address >> 6).
- R3: Bit 5 of the beat byte address selects the half. 0 places the beat on `s_wdata[255:0]` and `s_be[31:0]`; 1 places it on `s_wdata[511:256]` and `s_be[63:32]`. A half that carries no beat has zero data and zero byte enables.
- R4: Within a burst, the byte address of beat k is the first address plus 32*k. `m_addr` is ignored on every beat after the first.
- R5: `m_be` is copied unchanged into the 32 byte enables of the selected half, so partial narrow writes stay partial.
- R6: With packing on, a lower-half beat that is not the last beat of its burst is accepted with `m_wait` low and no slave write.
- R7: With packing on, an upper-half beat that follows a held lower-half beat produces one slave write. That write carries both halves, with the held byte enables in the lower 32 and the current ones in the upper 32.
- R8: With packing on, a burst that starts on the upper half emits that first beat alone, with only its upper enables. A burst whose last beat falls on the lower half emits that beat alone, with only its lower enables.
- R9: With packing on, every slave write of a burst carries `s_addr` = (first byte address >> 6) and `s_burst` = ceil((N + h0) / 2). N is the master burst count and h0 is bit 5 of the first address.
- R10: Whenever a slave write is presented, `m_wait` equals `s_wait`. While it is stalled, the beat is not consumed.
- R11: `pack_mode` and `m_burst` are sampled only on the first beat of a burst. Their values on later beats have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pack_mode | input | 1 | 1 merges beat pairs, 0 emits one wide write per beat; sampled on first beat |
| m_addr | input | 64 | Master byte address, valid on first beat of a burst |
| m_wdata | input | 256 | Master write data |
| m_be | input | 32 | Master byte enables |
| m_burst | input | 8 | Master burst length in beats, valid on first beat |
| m_write | input | 1 | Master write request |
| m_wait | output | 1 | Stall to the master |
| s_addr | output | 30 | Slave word address |
| s_wdata | output | 512 | Slave write data |
| s_be | output | 64 | Slave byte enables |
| s_burst | output | 8 | Slave burst length in wide beats |
| s_write | output | 1 | Slave write request |
| s_wait | input | 1 | Stall from the slave |

## Verification
The bench drives bursts that start on either half, with odd and even lengths, in both modes. A design that reused the bus address would put the second beat of a burst onto the lower half again and overwrite the first beat. A design that left the unused half enabled would write zeros over live data. On every beat after the first, the bench drives junk on `m_addr`, `m_burst` and `pack_mode`, which exposes any late sampling. Slave stalls are placed on merged beats and on lone beats to catch a pair being lost or consumed twice. A reset in the middle of a held pair shows whether a stale half leaks into the next write.

// File: rtl/nww_pkg.sv
package nww_pkg;

    // What the adapter does with the master beat presented this cycle
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,  // no master request
        ACT_HOLD = 2'd1,  // park the beat, no slave write
        ACT_EMIT = 2'd2   // present a slave write
    } beat_act_e;

endpackage

// File: rtl/nww_beat_ctrl.sv
module nww_beat_ctrl
    import nww_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int SADDR_W  = 30,
    parameter int BURST_W  = 8,
    parameter int LANE_LSB = 5,
    parameter int LANE_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pack_mode,
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic [BURST_W-1:0] m_burst,
    input  logic               m_write,
    input  logic               accept,
    output beat_act_e          act,
    output logic               pk,
    output logic [LANE_W-1:0]  lane,
    output logic [SADDR_W-1:0] beat_word,
    output logic [SADDR_W-1:0] start_word,
    output logic [BURST_W-1:0] wide_burst
);

    localparam int NB       = 1 << LANE_LSB;
    localparam int RATIO    = 1 << LANE_W;
    localparam int WORD_LSB = LANE_LSB + LANE_W;
    localparam int SUM_W    = BURST_W + LANE_W + 1;

    typedef struct packed {
        logic               busy;
        logic               pk;
        logic [BURST_W-1:0] left;
        logic [BURST_W-1:0] wburst;
        logic [ADDR_W-1:0]  eff;
        logic [ADDR_W-1:0]  start;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic               first;
    logic [ADDR_W-1:0]  beat_addr;
    logic [ADDR_W-1:0]  start_addr;
    logic [BURST_W-1:0] cur_left;
    logic [LANE_W-1:0]  lane0;
    logic [SUM_W-1:0]   span;

    always_comb begin
        first      = !ctl_q.busy;
        beat_addr  = first ? m_addr    : ctl_q.eff;
        start_addr = first ? m_addr    : ctl_q.start;
        cur_left   = first ? m_burst   : ctl_q.left;
        pk         = first ? pack_mode : ctl_q.pk;
        lane       = beat_addr[LANE_LSB +: LANE_W];
        lane0      = start_addr[LANE_LSB +: LANE_W];
        beat_word  = beat_addr[WORD_LSB +: SADDR_W];
        start_word = start_addr[WORD_LSB +: SADDR_W];
        span       = SUM_W'(m_burst) + SUM_W'(lane0) + SUM_W'(RATIO - 1);
        wide_burst = first ? BURST_W'(span >> LANE_W) : ctl_q.wburst;

        if (!m_write)
            act = ACT_NONE;
        else if (pk && (lane != {LANE_W{1'b1}}) && (cur_left > BURST_W'(1)))
            act = ACT_HOLD;
        else
            act = ACT_EMIT;

        ctl_d = ctl_q;
        if (accept) begin
            if (cur_left <= BURST_W'(1)) begin
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.busy   = 1'b1;
                ctl_d.left   = cur_left - BURST_W'(1);
                ctl_d.eff    = beat_addr + ADDR_W'(NB);
                ctl_d.pk     = pk;
                ctl_d.start  = start_addr;
                ctl_d.wburst = wide_burst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R10: a stalled beat leaves the burst state untouched
    a_r10_stall_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && !accept) |=> $stable(ctl_q));

    // R4: the beat after an accepted non-final beat sits one lane further on
    a_r4_lane_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_left > BURST_W'(1)) |=> (lane == $past(lane) + LANE_W'(1)));

    // R9: the wide burst count stays fixed for the rest of the burst
    a_r9_burst_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_left > BURST_W'(1)) |=> (wide_burst == $past(wide_burst)));

endmodule

// File: rtl/nww_lane_hold.sv
module nww_lane_hold #(
    parameter int NW     = 256,
    parameter int LANE_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          clear,
    input  logic [LANE_W-1:0]             lane,
    input  logic [NW-1:0]                 cur_data,
    input  logic [NW/8-1:0]               cur_be,
    output logic [(1<<LANE_W)-1:0][NW-1:0]   held_data,
    output logic [(1<<LANE_W)-1:0][NW/8-1:0] held_be,
    output logic [(1<<LANE_W)-1:0]        held_vld
);

    localparam int RATIO = 1 << LANE_W;
    localparam int NB    = NW / 8;

    typedef struct packed {
        logic [RATIO-1:0]         vld;
        logic [RATIO-1:0][NB-1:0] be;
        logic [RATIO-1:0][NW-1:0] data;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (clear) hold_d.vld = '0;
        if (load) begin
            hold_d.data[lane] = cur_data;
            hold_d.be[lane]   = cur_be;
            hold_d.vld[lane]  = 1'b1;
        end
        held_data = hold_q.data;
        held_be   = hold_q.be;
        held_vld  = hold_q.vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    // R6: a parked beat never lands on a slot that is still occupied
    a_r6_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !hold_q.vld[lane]);

    // R7: one beat is either parked or emitted, never both
    a_r7_load_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && clear));

endmodule

// File: rtl/nww_lane_steer.sv
module nww_lane_steer #(
    parameter int NW     = 256,
    parameter int LANE_W = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pk,
    input  logic [LANE_W-1:0]                lane,
    input  logic [NW-1:0]                    cur_data,
    input  logic [NW/8-1:0]                  cur_be,
    input  logic [(1<<LANE_W)-1:0][NW-1:0]   held_data,
    input  logic [(1<<LANE_W)-1:0][NW/8-1:0] held_be,
    input  logic [(1<<LANE_W)-1:0]           held_vld,
    output logic [(NW<<LANE_W)-1:0]          wide_data,
    output logic [(NW<<LANE_W)/8-1:0]        wide_be
);

    localparam int RATIO = 1 << LANE_W;
    localparam int NB    = NW / 8;

    logic [RATIO-1:0] lane_on;

    for (genvar i = 0; i < RATIO; i++) begin : g_lane
        logic hit;
        logic use_held;
        assign hit      = (lane == LANE_W'(i));
        assign use_held = pk && held_vld[i];
        assign wide_data[i*NW +: NW] = hit ? cur_data : (use_held ? held_data[i] : '0);
        assign wide_be[i*NB +: NB]   = hit ? cur_be   : (use_held ? held_be[i]   : '0);
        assign lane_on[i]            = |wide_be[i*NB +: NB];
    end

    // R3: without packing at most one half carries enables
    a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !pk |-> ($countones(lane_on) <= 1));

endmodule

// File: rtl/nww_write_widener.sv
module nww_write_widener
    import nww_pkg::*;
#(
    parameter int NARROW_W = 256,
    parameter int WIDE_W   = 512,
    parameter int ADDR_W   = 64,
    parameter int SADDR_W  = 30,
    parameter int BURST_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pack_mode,
    input  logic [ADDR_W-1:0]     m_addr,
    input  logic [NARROW_W-1:0]   m_wdata,
    input  logic [NARROW_W/8-1:0] m_be,
    input  logic [BURST_W-1:0]    m_burst,
    input  logic                  m_write,
    output logic                  m_wait,
    output logic [SADDR_W-1:0]    s_addr,
    output logic [WIDE_W-1:0]     s_wdata,
    output logic [WIDE_W/8-1:0]   s_be,
    output logic [BURST_W-1:0]    s_burst,
    output logic                  s_write,
    input  logic                  s_wait
);

    localparam int NB       = NARROW_W / 8;
    localparam int RATIO    = WIDE_W / NARROW_W;
    localparam int LANE_LSB = $clog2(NB);
    localparam int LANE_W   = $clog2(RATIO);

    beat_act_e          act;
    logic               pk;
    logic [LANE_W-1:0]  lane;
    logic [SADDR_W-1:0] beat_word;
    logic [SADDR_W-1:0] start_word;
    logic [BURST_W-1:0] wide_burst;
    logic               accept;
    logic               hold_beat;
    logic               emit_beat;

    logic [RATIO-1:0][NARROW_W-1:0] held_data;
    logic [RATIO-1:0][NB-1:0]       held_be;
    logic [RATIO-1:0]               held_vld;

    always_comb begin
        hold_beat = (act == ACT_HOLD);
        emit_beat = (act == ACT_EMIT);
        m_wait    = hold_beat ? 1'b0 : s_wait;
        accept    = m_write && !m_wait;
        s_write   = emit_beat;
        s_addr    = pk ? start_word : beat_word;
        s_burst   = pk ? wide_burst : BURST_W'(1);
    end

    nww_beat_ctrl #(
        .ADDR_W  (ADDR_W),
        .SADDR_W (SADDR_W),
        .BURST_W (BURST_W),
        .LANE_LSB(LANE_LSB),
        .LANE_W  (LANE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pack_mode (pack_mode),
        .m_addr    (m_addr),
        .m_burst   (m_burst),
        .m_write   (m_write),
        .accept    (accept),
        .act       (act),
        .pk        (pk),
        .lane      (lane),
        .beat_word (beat_word),
        .start_word(start_word),
        .wide_burst(wide_burst)
    );

    nww_lane_hold #(
        .NW    (NARROW_W),
        .LANE_W(LANE_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && hold_beat),
        .clear    (accept && emit_beat),
        .lane     (lane),
        .cur_data (m_wdata),
        .cur_be   (m_be),
        .held_data(held_data),
        .held_be  (held_be),
        .held_vld (held_vld)
    );

    nww_lane_steer #(
        .NW    (NARROW_W),
        .LANE_W(LANE_W)
    ) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pk       (pk),
        .lane     (lane),
        .cur_data (m_wdata),
        .cur_be   (m_be),
        .held_data(held_data),
        .held_be  (held_be),
        .held_vld (held_vld),
        .wide_data(s_wdata),
        .wide_be  (s_be)
    );

    // R1: no slave write without a master request
    a_r1_quiet_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !m_write |-> !s_write);

    // R10: a presented slave write passes the slave stall straight back
    a_r10_wait_passes: assert property (@(posedge clk) disable iff (!rst_n)
        s_write |-> (m_wait == s_wait));

    // R6: a beat that is parked is never stalled
    a_r6_park_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && !s_write) |-> !m_wait);

    // R9: every slave write carries a non-zero burst length
    a_r9_burst_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_write |-> (s_burst != '0));

endmodule

// File: tb/tb_nww_write_widener.sv
module tb_nww_write_widener;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pack_mode = 1'b0;
    logic [63:0]  m_addr = '0;
    logic [255:0] m_wdata = '0;
    logic [31:0]  m_be = '0;
    logic [7:0]   m_burst = '0;
    logic         m_write = 1'b0;
    logic         m_wait;
    logic [29:0]  s_addr;
    logic [511:0] s_wdata;
    logic [63:0]  s_be;
    logic [7:0]   s_burst;
    logic         s_write;
    logic         s_wait = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nww_write_widener dut (
        .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be), .m_burst(m_burst),
        .m_write(m_write), .m_wait(m_wait),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_be(s_be), .s_burst(s_burst),
        .s_write(s_write), .s_wait(s_wait)
    );

    // pk, first address, beats, partial enables, stall once, expected slave writes
    typedef struct packed {
        logic        pk;
        logic [63:0] addr;
        logic [7:0]  n;
        logic        part;
        logic        stall;
        logic [7:0]  nwr;
    } scn_t;

    localparam scn_t SCN [10] = '{
        '{1'b0, 64'h200, 8'd2, 1'b0, 1'b0, 8'd2},
        '{1'b0, 64'h220, 8'd3, 1'b0, 1'b1, 8'd3},
        '{1'b1, 64'h200, 8'd2, 1'b0, 1'b0, 8'd1},
        '{1'b1, 64'h220, 8'd3, 1'b0, 1'b0, 8'd2},
        '{1'b1, 64'h200, 8'd3, 1'b1, 1'b0, 8'd2},
        '{1'b1, 64'h240, 8'd1, 1'b0, 1'b0, 8'd1},
        '{1'b1, 64'h260, 8'd1, 1'b0, 1'b1, 8'd1},
        '{1'b0, 64'h000, 8'd1, 1'b1, 1'b0, 8'd1},
        '{1'b1, 64'h400, 8'd4, 1'b0, 1'b1, 8'd2},
        '{1'b1, 64'h7E0, 8'd2, 1'b1, 1'b0, 8'd2}
    };

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_data(input int s, input int k);
        return {8{32'h5A00_0000 + 32'(s * 16 + k)}};
    endfunction

    task automatic run_scn(input int s);
        scn_t         c;
        int           wr;
        bit           stalled;
        logic [255:0] prev_d;
        logic [31:0]  prev_be;
        c = SCN[s];
        wr = 0;
        stalled = 1'b0;
        prev_d = '0;
        prev_be = '0;
        for (int k = 0; k < int'(c.n); k++) begin
            int           lane;
            logic [63:0]  ba;
            logic [255:0] d;
            logic [31:0]  be;
            bit           ew;
            logic [511:0] ed;
            logic [63:0]  ebe;
            logic [29:0]  ea;
            logic [7:0]   eb;
            lane = int'(c.addr[5]) ^ (k & 1);
            ba   = c.addr + 64'(32 * k);
            d    = mk_data(s, k);
            be   = c.part ? (32'h00FF_0F0F ^ 32'(k)) : 32'hFFFF_FFFF;
            ew   = !(c.pk && lane == 0 && k < int'(c.n) - 1);
            ed   = (lane == 1) ? {d, 256'b0} : {256'b0, d};
            ebe  = (lane == 1) ? {be, 32'b0} : {32'b0, be};
            if (c.pk && lane == 1 && k > 0) begin
                ed[255:0] = prev_d;
                ebe[31:0] = prev_be;
            end
            ea = c.pk ? c.addr[35:6] : ba[35:6];
            eb = c.pk ? 8'((int'(c.n) + int'(c.addr[5]) + 1) / 2) : 8'd1;

            m_write = 1'b1;
            m_wdata = d;
            m_be    = be;
            if (k == 0) begin
                m_addr = c.addr; m_burst = c.n; pack_mode = c.pk;
            end else begin
                // R4/R11: junk on the sideband after the first beat
                m_addr = 64'hFFFF_FFFF_FFFF_FFE0; m_burst = 8'd77; pack_mode = !c.pk;
            end

            if (c.stall && ew && !stalled) begin
                s_wait = 1'b1;
                @(negedge clk);
                chk("R10 stall reaches master", 512'(m_wait), 512'(1));
                chk("R10 write held during stall", 512'(s_write), 512'(1));
                @(posedge clk); #1;
                s_wait = 1'b0;
                stalled = 1'b1;
            end

            @(negedge clk);
            chk(k > 0 ? "R6/R11 write strobe" : "R2/R6 write strobe", 512'(s_write), 512'(ew));
            if (ew) begin
                chk(c.pk ? "R9 packed address" : (k > 0 ? "R4 beat address" : "R2 word address"),
                    512'(s_addr), 512'(ea));
                chk(c.pk ? "R9 packed burst" : "R2 single burst", 512'(s_burst), 512'(eb));
                chk("R3/R7/R8 wide data", s_wdata, ed);
                chk("R5/R7/R8 byte enables", 512'(s_be), 512'(ebe));
            end else begin
                chk("R6 parked beat not stalled", 512'(m_wait), 512'(0));
            end
            if (s_write) wr++;
            prev_d  = d;
            prev_be = be;
            @(posedge clk); #1;
        end
        m_write = 1'b0;
        chk("R7/R8 slave write count", 512'(wr), 512'(c.nwr));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: idle through reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 idle in reset", 512'(s_write), 512'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        s_wait = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 512'(s_write), 512'(0));
        chk("R10 idle wait follows slave", 512'(m_wait), 512'(1));
        @(posedge clk); #1;
        s_wait = 1'b0;

        for (int s = 0; s < 10; s++) run_scn(s);

        // R1: reset in the middle of a parked pair
        m_write = 1'b1; pack_mode = 1'b1; m_addr = 64'h800; m_burst = 8'd2;
        m_wdata = {8{32'hDEAD_0001}}; m_be = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R6 pair start parked", 512'(s_write), 512'(0));
        @(posedge clk); #1;
        m_write = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        m_write = 1'b1; pack_mode = 1'b1; m_addr = 64'h860; m_burst = 8'd1;
        m_wdata = {8{32'h0BAD_F00D}}; m_be = 32'h0000_FFFF;
        @(negedge clk);
        chk("R1 write after reset", 512'(s_write), 512'(1));
        chk("R1 no stale half in enables", 512'(s_be), 512'({32'h0000_FFFF, 32'b0}));
        chk("R1 no stale half in data", s_wdata, {{8{32'h0BAD_F00D}}, 256'b0});
        chk("R9 lone upper address", 512'(s_addr), 512'(30'h21));
        chk("R8 lone upper burst", 512'(s_burst), 512'(1));
        @(posedge clk); #1;
        m_write = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule